// File: doc/BRIEF.md
# Multiplexed-Bus Register File with Detect Interrupt

This block is the host-facing register file of a peripheral that sits on an 8-bit multiplexed address/data bus. The host first pulses an address-latch strobe. On its falling edge the block captures a 3-bit register address from the low bus bits and records whether its active-low chip select was asserted. A read or write cycle then follows on separate active-low read and write strobes. The pad is modelled as three signals: an input bus, an output bus and an output enable. A real tri-state driver can be built from them outside the block.

Inside are two control registers, a tone register and a detect register. The two control registers carry the operating mode, a data-rate field and an output-clock select. The detect register gathers event pulses from the rest of the chip and drives an active-low interrupt. The host clears that register by reading it.

A clock-output multiplexer passes the crystal clock through by default. It switches to a divided baud clock only when software selects that clock and the mode field names one of the two DPSK modes.

Top module: `mbus_regfile`

## Requirements
- R1: On the cycle where the address-latch strobe `ale_i` is seen falling, the block captures `bus_in_i[2:0]` as the register address and latches "selected" when `cs_n_i` is low. The upper bus bits play no part in the address.
- R2: When the latched select is inactive, `bus_oe_o` stays low, `bus_out_o` reads zero, and no register changes on a write strobe.
- R3: `bus_oe_o` is high only while `rd_n_i` is low and the latched select is active. During a read, `bus_out_o` shows the addressed register. Addresses 4 to 7 read as zero.
- R4: A write takes `bus_in_i` on the rising edge of `wr_n_i`. Address 0 writes control register 0, address 1 writes control register 1 and address 3 writes the tone register. Address 2 (detect) and addresses 4 to 7 ignore writes.
- R5: A high bit on `det_set_i` sets the matching detect bit, and `irq_n_o` is low from the next clock cycle.
- R6: A read of address 2 returns the detect bits that were set when the read strobe fell, and clears exactly those bits when the strobe rises. `irq_n_o` goes high again once no detect bit remains set.
- R7: A detect bit that sets while a detect read is in progress is not returned by that read. It survives the clear, `irq_n_o` stays low, and the next read returns it.
- R8: A high `rst` clears both control registers, the tone register and the detect register. It drops the latched select and drives `irq_n_o` high, and `clk_out_o` follows the crystal clock.
- R9: `clk_out_o` carries the baud clock only when control register 1 bit 0 is 1 and control register 0 bits [1:0] hold 2 or 3 (the DPSK modes). In every other case it carries the crystal clock `clk`.
- R10: The baud clock starts low and toggles every `BASE_HALF << rate` crystal cycles, where rate is control register 0 bits [3:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock, also the block's system clock |
| rst | input | 1 | Synchronous active-high reset |
| ale_i | input | 1 | Address-latch strobe; its falling edge captures address and select |
| cs_n_i | input | 1 | Active-low chip select, sampled at the latch edge |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe; data taken on its rising edge |
| bus_in_i | input | DW | Bus value as seen by the block |
| bus_out_o | output | DW | Read data, zero when not driving |
| bus_oe_o | output | 1 | High while the block should drive the bus |
| det_set_i | input | NDET | Detect event pulses, one per bit |
| irq_n_o | output | 1 | Active-low interrupt |
| clk_out_o | output | 1 | Selected output clock: crystal or baud |
| ctrl0_o | output | DW | Control register 0 (mode [1:0], rate [3:2]) |
| ctrl1_o | output | DW | Control register 1 (bit 0 selects baud clock) |
| tone_o | output | DW | Tone register |

## Verification
The bench covers every address, with several data patterns each. A decoder that used more than three bus bits, let writes into the detect register, or echoed stale data on unused addresses would fail the read-back. It repeats the cycles with the select high at the latch edge. A design that sampled chip select late, or enabled the driver from the read strobe alone, would drive the bus or change a register there.

It injects a detect event during an open detect read. A clear-everything read would lose that event and release the interrupt too early.

It sweeps all modes, select values and rates while counting clock-output toggles. A divider with an off-by-one limit, or a mux that ignored the DPSK condition, would show the wrong toggle count.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL0 = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL1 = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_DET   = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_TONE  = 3'd3;

    typedef enum logic [1:0] {
        MD_IDLE    = 2'd0,
        MD_FSK     = 2'd1,
        MD_DPSK_HI = 2'd2,
        MD_DPSK_LO = 2'd3
    } mode_e;

    // Latched bus-cycle context
    typedef struct packed {
        logic              sel;
        logic [ADDR_W-1:0] addr;
    } cyc_t;

    // Strobe events, valid for one clock
    typedef struct packed {
        logic wr_done;
        logic rd_start;
        logic rd_done;
    } strobe_ev_t;

    function automatic logic is_dpsk(input mode_e m);
        return (m == MD_DPSK_HI) || (m == MD_DPSK_LO);
    endfunction

    function automatic int unsigned half_cycles(input int unsigned base, input logic [1:0] rate);
        return base << rate;
    endfunction

endpackage

// File: rtl/mbus_latch.sv
module mbus_latch
    import mbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ale_i,
    input  logic              cs_n_i,
    input  logic              rd_n_i,
    input  logic              wr_n_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    output cyc_t              cyc_o,
    output strobe_ev_t        ev_o,
    output logic              rd_active_o
);

    logic ale_q;
    logic rd_n_q;
    logic wr_n_q;
    logic rd_act_q;
    cyc_t cyc_q;
    logic ale_fall;

    assign ale_fall = ale_q & ~ale_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q  <= 1'b0;
            rd_n_q <= 1'b1;
            wr_n_q <= 1'b1;
        end else begin
            ale_q  <= ale_i;
            rd_n_q <= rd_n_i;
            wr_n_q <= wr_n_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q <= '0;
        end else if (ale_fall) begin
            cyc_q.sel  <= ~cs_n_i;
            cyc_q.addr <= bus_addr_i;
        end
    end

    always_comb begin
        ev_o.wr_done  = cyc_q.sel & ~wr_n_q & wr_n_i;
        ev_o.rd_start = cyc_q.sel & rd_n_q & ~rd_n_i & ~rd_act_q;
        ev_o.rd_done  = rd_act_q & rd_n_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_act_q <= 1'b0;
        end else if (ev_o.rd_start) begin
            rd_act_q <= 1'b1;
        end else if (ev_o.rd_done) begin
            rd_act_q <= 1'b0;
        end
    end

    assign cyc_o       = cyc_q;
    assign rd_active_o = rd_act_q;

endmodule

// File: rtl/mbus_regs.sv
module mbus_regs
    import mbus_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NDET = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  cyc_t            cyc_i,
    input  strobe_ev_t      ev_i,
    input  logic            rd_active_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [NDET-1:0] det_set_i,
    output logic [DW-1:0]   ctrl0_o,
    output logic [DW-1:0]   ctrl1_o,
    output logic [DW-1:0]   tone_o,
    output logic [DW-1:0]   rdata_o,
    output logic            irq_o
);

    logic [DW-1:0]   ctrl0_q;
    logic [DW-1:0]   ctrl1_q;
    logic [DW-1:0]   tone_q;
    logic [NDET-1:0] det_q;
    logic [NDET-1:0] det_next;
    logic [NDET-1:0] snap_q;
    logic            irq_q;
    logic            det_clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl0_q <= '0;
            ctrl1_q <= '0;
            tone_q  <= '0;
        end else if (ev_i.wr_done) begin
            case (cyc_i.addr)
                ADDR_CTRL0: ctrl0_q <= wdata_i;
                ADDR_CTRL1: ctrl1_q <= wdata_i;
                ADDR_TONE:  tone_q  <= wdata_i;
                default: ;
            endcase
        end
    end

    assign det_clear = ev_i.rd_done && (cyc_i.addr == ADDR_DET);

    // One cell per detect bit: set by event, cleared only if it was read
    for (genvar g = 0; g < NDET; g++) begin : g_det
        always_comb begin
            det_next[g] = (det_q[g] & ~(det_clear & snap_q[g])) | det_set_i[g];
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                det_q[g] <= 1'b0;
            end else begin
                det_q[g] <= det_next[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (ev_i.rd_start) begin
                snap_q <= det_q;
            end
            irq_q <= |det_next;
        end
    end

    always_comb begin
        case (cyc_i.addr)
            ADDR_CTRL0: rdata_o = ctrl0_q;
            ADDR_CTRL1: rdata_o = ctrl1_q;
            ADDR_DET:   rdata_o = rd_active_i ? DW'(snap_q) : DW'(det_q);
            ADDR_TONE:  rdata_o = tone_q;
            default:    rdata_o = '0;
        endcase
    end

    assign ctrl0_o = ctrl0_q;
    assign ctrl1_o = ctrl1_q;
    assign tone_o  = tone_q;
    assign irq_o   = irq_q;

endmodule

// File: rtl/mbus_clkgen.sv
module mbus_clkgen
    import mbus_pkg::*;
#(
    parameter int unsigned BASE_HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel_baud_i,
    input  mode_e      mode_i,
    input  logic [1:0] rate_i,
    output logic       clk_out_o,
    output logic       use_baud_o
);

    localparam int unsigned MAX_HALF = BASE_HALF << 3;
    localparam int          CW       = $clog2(MAX_HALF + 1);

    logic          use_q;
    logic          baud_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] limit;

    assign limit = CW'(half_cycles(BASE_HALF, rate_i) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            use_q <= 1'b0;
        end else begin
            use_q <= sel_baud_i & is_dpsk(mode_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !use_q) begin
            cnt_q  <= '0;
            baud_q <= 1'b0;
        end else if (cnt_q >= limit) begin
            cnt_q  <= '0;
            baud_q <= ~baud_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign clk_out_o  = use_q ? baud_q : clk;
    assign use_baud_o = use_q;

endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
    import mbus_pkg::*;
#(
    parameter int          DW        = 8,
    parameter int          NDET      = 4,
    parameter int unsigned BASE_HALF = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ale_i,
    input  logic            cs_n_i,
    input  logic            rd_n_i,
    input  logic            wr_n_i,
    input  logic [DW-1:0]   bus_in_i,
    output logic [DW-1:0]   bus_out_o,
    output logic            bus_oe_o,
    input  logic [NDET-1:0] det_set_i,
    output logic            irq_n_o,
    output logic            clk_out_o,
    output logic [DW-1:0]   ctrl0_o,
    output logic [DW-1:0]   ctrl1_o,
    output logic [DW-1:0]   tone_o
);

    cyc_t          cyc_q;
    strobe_ev_t    ev;
    logic          rd_active;
    logic [DW-1:0] rdata;
    logic          irq;
    logic          use_baud;

    mbus_latch i_latch (
        .clk        (clk),
        .rst        (rst),
        .ale_i      (ale_i),
        .cs_n_i     (cs_n_i),
        .rd_n_i     (rd_n_i),
        .wr_n_i     (wr_n_i),
        .bus_addr_i (bus_in_i[ADDR_W-1:0]),
        .cyc_o      (cyc_q),
        .ev_o       (ev),
        .rd_active_o(rd_active)
    );

    mbus_regs #(.DW(DW), .NDET(NDET)) i_regs (
        .clk        (clk),
        .rst        (rst),
        .cyc_i      (cyc_q),
        .ev_i       (ev),
        .rd_active_i(rd_active),
        .wdata_i    (bus_in_i),
        .det_set_i  (det_set_i),
        .ctrl0_o    (ctrl0_o),
        .ctrl1_o    (ctrl1_o),
        .tone_o     (tone_o),
        .rdata_o    (rdata),
        .irq_o      (irq)
    );

    mbus_clkgen #(.BASE_HALF(BASE_HALF)) i_clkgen (
        .clk       (clk),
        .rst       (rst),
        .sel_baud_i(ctrl1_o[0]),
        .mode_i    (mode_e'(ctrl0_o[1:0])),
        .rate_i    (ctrl0_o[3:2]),
        .clk_out_o (clk_out_o),
        .use_baud_o(use_baud)
    );

    assign bus_oe_o  = cyc_q.sel & ~rd_n_i;
    assign bus_out_o = bus_oe_o ? rdata : '0;
    assign irq_n_o   = ~irq;

endmodule

// File: rtl/mbus_regfile_chk.sv
module mbus_regfile_chk #(
    parameter int DW   = 8,
    parameter int NDET = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            rd_n_i,
    input logic            bus_oe_o,
    input logic [DW-1:0]   bus_out_o,
    input logic [NDET-1:0] det_set_i,
    input logic            irq_n_o,
    input logic [DW-1:0]   ctrl0_o,
    input logic [DW-1:0]   ctrl1_o,
    input logic [DW-1:0]   tone_o,
    input logic            sel_q,
    input logic            det_rd_done,
    input logic            use_baud
);

    // R3
    oe_needs_rd_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe_o |-> !rd_n_i);

    // R2
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_oe_o |-> (bus_out_o == '0));

    // R2
    unsel_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_q |=> $stable({ctrl0_o, ctrl1_o, tone_o}));

    // R5
    detect_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (|det_set_i) |=> !irq_n_o);

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq_n_o && !det_rd_done) |=> !irq_n_o);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ctrl0_o == '0 && ctrl1_o == '0 && tone_o == '0 && irq_n_o && !use_baud));

    // R9
    crystal_default_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctrl1_o[0] && ctrl0_o[1]) |=> !use_baud);

endmodule

bind mbus_regfile mbus_regfile_chk #(.DW(DW), .NDET(NDET)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .rd_n_i     (rd_n_i),
    .bus_oe_o   (bus_oe_o),
    .bus_out_o  (bus_out_o),
    .det_set_i  (det_set_i),
    .irq_n_o    (irq_n_o),
    .ctrl0_o    (ctrl0_o),
    .ctrl1_o    (ctrl1_o),
    .tone_o     (tone_o),
    .sel_q      (cyc_q.sel),
    .det_rd_done(ev.rd_done && (cyc_q.addr == mbus_pkg::ADDR_DET)),
    .use_baud   (use_baud)
);

// File: tb/test_mbus_regfile.sv
module test_mbus_regfile;

    localparam int          CLK_PERIOD = 10;
    localparam int          DW         = 8;
    localparam int          NDET       = 4;
    localparam int unsigned BASE_HALF  = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ale = 1'b0;
    logic            cs_n = 1'b1;
    logic            rd_n = 1'b1;
    logic            wr_n = 1'b1;
    logic [DW-1:0]   bus_in = '0;
    logic [DW-1:0]   bus_out;
    logic            bus_oe;
    logic [NDET-1:0] det_set = '0;
    logic            irq_n;
    logic            clk_out;
    logic [DW-1:0]   ctrl0, ctrl1, tone;

    int n_run  = 0;
    int n_fail = 0;
    logic [DW-1:0] model [0:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    mbus_regfile #(.DW(DW), .NDET(NDET), .BASE_HALF(BASE_HALF)) i_mbus_regfile (
        .clk(clk), .rst(rst), .ale_i(ale), .cs_n_i(cs_n), .rd_n_i(rd_n), .wr_n_i(wr_n),
        .bus_in_i(bus_in), .bus_out_o(bus_out), .bus_oe_o(bus_oe), .det_set_i(det_set),
        .irq_n_o(irq_n), .clk_out_o(clk_out), .ctrl0_o(ctrl0), .ctrl1_o(ctrl1), .tone_o(tone)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic latch_phase(input logic [2:0] a, input logic [DW-1:0] hi, input logic sel);
        @(negedge clk);
        ale = 1'b1; cs_n = ~sel; bus_in = hi | DW'(a);
        @(negedge clk);
        ale = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [DW-1:0] d, input logic sel);
        latch_phase(a, 8'hF8, sel);
        @(negedge clk);
        bus_in = d; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; bus_in = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, input logic sel, input logic [NDET-1:0] inj,
                            output logic [DW-1:0] d, output logic oe);
        latch_phase(a, 8'h00, sel);
        @(negedge clk);
        rd_n = 1'b0; det_set = inj;
        @(negedge clk);
        d = bus_out; oe = bus_oe;
        det_set = '0; rd_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic pulse_det(input logic [NDET-1:0] v);
        @(negedge clk);
        det_set = v;
        @(negedge clk);
        det_set = '0;
    endtask

    task automatic count_toggles(input int w, output int n);
        logic prev;
        n = 0;
        @(negedge clk); #1 prev = clk_out;
        repeat (w) begin
            @(negedge clk); #1;
            if (clk_out !== prev) n++;
            prev = clk_out;
        end
    endtask

    task automatic crystal_phase(output logic hi, output logic lo);
        @(posedge clk); #(CLK_PERIOD/4) hi = clk_out;
        @(negedge clk); #(CLK_PERIOD/4) lo = clk_out;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] d;
        logic oe, hi, lo;
        int n;
        logic [DW-1:0] pats [0:4];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A; pats[4] = 8'h3C;
        for (int i = 0; i < 8; i++) model[i] = '0;

        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 ctrl0", ctrl0, 0);
        chk("R8 irq_n", irq_n, 1);
        chk("R8 oe", bus_oe, 0);
        rst = 1'b0;
        @(negedge clk);
        rd_n = 1'b0;
        @(negedge clk); #1;
        chk("R8 no select after reset", bus_oe, 0);
        rd_n = 1'b1;

        // R4 R3 R1: sweep addresses and patterns (address bus bits 7:3 set during latch)
        for (int p = 0; p < 5; p++) begin
            for (int a = 0; a < 8; a++) begin
                bus_write(3'(a), pats[p], 1'b1);
                if (a == 0 || a == 1 || a == 3) model[a] = pats[p];
            end
            for (int a = 0; a < 8; a++) begin
                bus_read(3'(a), 1'b1, '0, d, oe);
                chk("R3 oe during read", oe, 1);
                chk("R4 R1 readback", d, model[a]);
            end
        end
        chk("R4 tone port", tone, model[3]);

        // R2: unselected cycles neither drive nor write
        for (int a = 0; a < 4; a++) begin
            bus_write(3'(a), ~model[a], 1'b0);
            bus_read(3'(a), 1'b0, '0, d, oe);
            chk("R2 no drive oe", oe, 0);
            chk("R2 no drive data", d, 0);
            bus_read(3'(a), 1'b1, '0, d, oe);
            chk("R2 register unchanged", d, model[a]);
        end

        // R5 R6: each detect bit alone
        for (int b = 0; b < NDET; b++) begin
            pulse_det(NDET'(1 << b));
            #1 chk("R5 irq low", irq_n, 0);
            bus_read(3'd2, 1'b1, '0, d, oe);
            chk("R6 detect value", d, DW'(1 << b));
            #1 chk("R6 irq released", irq_n, 1);
            bus_read(3'd2, 1'b1, '0, d, oe);
            chk("R6 cleared", d, 0);
        end
        pulse_det(4'b1010);
        pulse_det(4'b0101);
        bus_read(3'd2, 1'b1, '0, d, oe);
        chk("R6 accumulated", d, 8'h0F);

        // R7: flag arriving during an open detect read
        pulse_det(4'b0001);
        bus_read(3'd2, 1'b1, 4'b0100, d, oe);
        chk("R7 read excludes new flag", d, 8'h01);
        #1 chk("R7 irq still low", irq_n, 0);
        bus_read(3'd2, 1'b1, '0, d, oe);
        chk("R7 held flag returned", d, 8'h04);
        #1 chk("R7 irq released", irq_n, 1);

        // R9 R10: all modes, selects and rates
        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                for (int r = 0; r < 4; r++) begin
                    int half;
                    logic baud;
                    half = int'(BASE_HALF) << r;
                    baud = (s == 1) && (m >= 2);
                    bus_write(3'd0, DW'((r << 2) | m), 1'b1);
                    bus_write(3'd1, DW'(s), 1'b1);
                    repeat (2 * half) @(negedge clk);
                    count_toggles(8 * half, n);
                    chk("R10 toggle count", n, baud ? 8 : 0);
                    if (!baud) begin
                        crystal_phase(hi, lo);
                        chk("R9 crystal high phase", hi, 1);
                        chk("R9 crystal low phase", lo, 0);
                    end
                end
            end
        end

        // R10: baud clock starts low
        bus_write(3'd1, 8'h00, 1'b1);
        bus_write(3'd0, 8'h0E, 1'b1);
        @(negedge clk); ctrl1_force_sel();
        @(negedge clk); #1;
        chk("R10 starts low", clk_out, 0);

        // R8: reset mid-operation
        bus_write(3'd3, 8'h77, 1'b1);
        pulse_det(4'b0011);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R8 ctrl0 cleared", ctrl0, 0);
        chk("R8 ctrl1 cleared", ctrl1, 0);
        chk("R8 tone cleared", tone, 0);
        chk("R8 irq high", irq_n, 1);
        crystal_phase(hi, lo);
        chk("R8 crystal out", {hi, lo}, 2'b10);
        bus_read(3'd2, 1'b1, '0, d, oe);
        chk("R8 detect cleared", d, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Select baud clock with a write and leave the bus idle after the data phase
    task automatic ctrl1_force_sel();
        latch_phase(3'd1, 8'h00, 1'b1);
        @(negedge clk);
        bus_in = 8'h01; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; bus_in = '0;
    endtask

endmodule